// File: doc/BRIEF.md
# ADC Result Window Watchdog

This block watches the stream of conversion results leaving an analog-to-digital converter. Each result arrives with a valid strobe, a channel index and a tag that says which of two scan sequences (A or B) produced it. The block compares the result with a low and a high threshold. In out-of-window mode a result that falls outside the thresholds counts as a hit. In in-window mode a result that falls between them, bounds included, counts as a hit. All comparisons are unsigned and use the result exactly as it arrives.

Only channels enabled in a channel mask are watched, and only while the block is enabled. A hit sets a sticky flag for its channel. Software can clear flags one at a time with a write-one-to-clear, or all at once. The interrupt line is the OR of all flags, gated by an interrupt enable. A one-cycle compare event also pulses on every hit, and a sequence filter can limit it to results from A only, B only or both. Software reaches the block through a plain write-enable register port with a combinational read path.

Top module: `adc_window_watch`

## Requirements
- R1: After reset every register reads 0, and irq_o and cmp_evt_o are 0.
- R2: In mode 0 (control bit 2 clear) a result is a hit when it is unsigned-less than the low threshold (address 1) or unsigned-greater than the high threshold (address 2). A result equal to either threshold is not a hit.
- R3: In mode 1 (control bit 2 set) a result is a hit when low <= result <= high, unsigned, with both bounds counted as hits.
- R4: A result is ignored when the enable (control bit 0) is clear or when its channel's bit in the mask register (address 3) is clear.
- R5: A hit on channel c sets bit c of the flag register (address 4) on the clock edge that samples the result. The bit stays set until it is cleared.
- R6: Writing address 4 clears each flag whose write-data bit is 1 and leaves the others alone. Writing any value to address 5 clears all flags. Reading address 5 returns 0.
- R7: When a clear and a hit on the same channel happen in the same cycle, the flag ends up set.
- R8: irq_o is 1 exactly when the interrupt enable (control bit 1) is set and at least one flag is set. Turning the interrupt enable off does not change the flags.
- R9: cmp_evt_o is 1 in the cycle after a hit whose sequence passes the filter in control bits [4:3]: 0 or 3 passes both sequences, 1 passes only A (res_seq=0), and 2 passes only B (res_seq=1). The filter has no effect on the flags.
- R10: The control bits [4:0], both thresholds and the mask read back as they were written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| res_valid | input | 1 | Result strobe |
| res_data | input | DATA_W | Conversion result |
| res_chan | input | CH_W | Channel index of the result |
| res_seq | input | 1 | Sequence tag: 0 = A, 1 = B |
| reg_we | input | 1 | Register write enable |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | DATA_W | Register write data |
| reg_rdata | output | DATA_W | Register read data (combinational) |
| irq_o | output | 1 | Interrupt line |
| cmp_evt_o | output | 1 | One-cycle compare event |

## Verification
The bench drives results exactly at each threshold and one step past it, in both modes. A design with an off-by-one compare would flag the boundary values or miss them. It clears a channel's flag in the same cycle as a hit on that channel, where a clear-wins design would lose the flag. It offers each sequence tag under every filter code, which exposes codes 0 and 3 being handled differently or the filter wrongly gating the flags. Masked and disabled channels receive matching results, so a design that skips the gating would raise flags for them.

// File: rtl/adc_window_watch.sv
module adc_window_watch #(
  parameter int DATA_W = 16,
  parameter int NUM_CH = 16,
  localparam int CH_W = $clog2(NUM_CH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              res_valid,
  input  logic [DATA_W-1:0] res_data,
  input  logic [CH_W-1:0]   res_chan,
  input  logic              res_seq,
  input  logic              reg_we,
  input  logic [2:0]        reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              irq_o,
  output logic              cmp_evt_o
);
  localparam logic [2:0] A_CTL = 3'd0, A_LO = 3'd1, A_HI = 3'd2,
                         A_MASK = 3'd3, A_FLAG = 3'd4, A_CLR = 3'd5;

  logic              ctl_en, ctl_irq_en, ctl_mode;
  logic [1:0]        ctl_sel;
  logic [DATA_W-1:0] thr_lo, thr_hi;
  logic [NUM_CH-1:0] ch_mask, flags, set_vec, clr_vec;
  logic              in_win, match, hit, seq_ok;

  assign in_win  = (res_data >= thr_lo) && (res_data <= thr_hi);
  assign match   = ctl_mode ? in_win : !in_win;
  assign hit     = res_valid && ctl_en && ch_mask[res_chan] && match;
  assign seq_ok  = (ctl_sel == 2'd1) ? !res_seq :
                   (ctl_sel == 2'd2) ?  res_seq : 1'b1;
  assign set_vec = hit ? (NUM_CH'(1) << res_chan) : '0;

  always_comb begin
    clr_vec = '0;
    if (reg_we && reg_addr == A_FLAG) clr_vec = reg_wdata[NUM_CH-1:0];
    if (reg_we && reg_addr == A_CLR)  clr_vec = '1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_en     <= 1'b0;
      ctl_irq_en <= 1'b0;
      ctl_mode   <= 1'b0;
      ctl_sel    <= 2'd0;
      thr_lo     <= '0;
      thr_hi     <= '0;
      ch_mask    <= '0;
    end else if (reg_we) begin
      case (reg_addr)
        A_CTL: begin
          ctl_en     <= reg_wdata[0];
          ctl_irq_en <= reg_wdata[1];
          ctl_mode   <= reg_wdata[2];
          ctl_sel    <= reg_wdata[4:3];
        end
        A_LO:    thr_lo  <= reg_wdata;
        A_HI:    thr_hi  <= reg_wdata;
        A_MASK:  ch_mask <= reg_wdata[NUM_CH-1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags     <= '0;
      cmp_evt_o <= 1'b0;
    end else begin
      flags     <= (flags & ~clr_vec) | set_vec;
      cmp_evt_o <= hit && seq_ok;
    end
  end

  assign irq_o = ctl_irq_en && (|flags);

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_CTL:   reg_rdata[4:0] = {ctl_sel, ctl_mode, ctl_irq_en, ctl_en};
      A_LO:    reg_rdata = thr_lo;
      A_HI:    reg_rdata = thr_hi;
      A_MASK:  reg_rdata[NUM_CH-1:0] = ch_mask;
      A_FLAG:  reg_rdata[NUM_CH-1:0] = flags;
      default: reg_rdata = '0;
    endcase
  end
endmodule

module adc_window_watch_chk #(
  parameter int NUM_CH = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              res_valid,
  input logic              res_seq,
  input logic              reg_we,
  input logic [2:0]        reg_addr,
  input logic              ctl_en,
  input logic [1:0]        ctl_sel,
  input logic [NUM_CH-1:0] flags,
  input logic              cmp_evt_o
);
  assert_evt_needs_result_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_evt_o |-> $past(res_valid && ctl_en));

  assert_evt_only_seq_a_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_evt_o && $past(ctl_sel == 2'd1)) |-> $past(!res_seq));

  assert_flag_rise_needs_result_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ((flags & ~$past(flags)) != '0) |-> $past(res_valid && ctl_en));

  assert_one_new_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(flags & ~$past(flags)));

  assert_clear_all_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $past(reg_we && reg_addr == 3'd5 && !res_valid) |-> (flags == '0));
endmodule

bind adc_window_watch adc_window_watch_chk #(.NUM_CH(NUM_CH)) u_chk (
  .clk(clk), .rst_n(rst_n), .res_valid(res_valid), .res_seq(res_seq),
  .reg_we(reg_we), .reg_addr(reg_addr), .ctl_en(ctl_en), .ctl_sel(ctl_sel),
  .flags(flags), .cmp_evt_o(cmp_evt_o)
);

// File: tb/tb_adc_window_watch.sv
module tb_adc_window_watch;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        res_valid = 1'b0;
  logic [15:0] res_data = '0;
  logic [3:0]  res_chan = '0;
  logic        res_seq = 1'b0;
  logic        reg_we = 1'b0;
  logic [2:0]  reg_addr = 3'd4;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic        irq_o, cmp_evt_o;

  int checks = 0, fails = 0;
  bit done = 0;

  logic        m_en = 0, m_ie = 0, m_mode = 0;
  logic [1:0]  m_sel = 0;
  logic [15:0] m_lo = 0, m_hi = 0, m_mask = 0, m_flags = 0;
  logic        m_evt = 0;

  always #10 clk = ~clk;

  adc_window_watch dut (
    .clk(clk), .rst_n(rst_n), .res_valid(res_valid), .res_data(res_data),
    .res_chan(res_chan), .res_seq(res_seq), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_o(irq_o), .cmp_evt_o(cmp_evt_o)
  );

  function automatic bit f_match(input logic [15:0] d);
    bit inside_w = (d >= m_lo) && (d <= m_hi);
    return m_mode ? inside_w : !inside_w;
  endfunction

  function automatic bit f_seq_ok(input bit seq);
    if (m_sel == 2'd1) return !seq;
    if (m_sel == 2'd2) return seq;
    return 1'b1;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic chk_outs(input string tag);
    reg_addr = 3'd4;
    #1;
    chk({tag, " flags"}, reg_rdata, m_flags);
    chk({tag, " event"}, cmp_evt_o, m_evt);
    chk({tag, " irq R8"}, irq_o, m_ie && (|m_flags));
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
    case (a)
      3'd0: begin m_en = d[0]; m_ie = d[1]; m_mode = d[2]; m_sel = d[4:3]; end
      3'd1: m_lo = d;
      3'd2: m_hi = d;
      3'd3: m_mask = d;
      3'd4: m_flags &= ~d;
      3'd5: m_flags = '0;
      default: ;
    endcase
    m_evt = 1'b0;
  endtask

  task automatic cfg(input bit en, input bit ie, input bit mode, input logic [1:0] sel,
                     input logic [15:0] lo, input logic [15:0] hi, input logic [15:0] mask);
    wr(3'd0, {11'd0, sel, mode, ie, en});
    wr(3'd1, lo);
    wr(3'd2, hi);
    wr(3'd3, mask);
  endtask

  task automatic drive(input string tag, input bit v, input logic [3:0] ch, input bit seq,
                       input logic [15:0] d, input bit we, input logic [2:0] a,
                       input logic [15:0] wd);
    bit hit;
    logic [15:0] nf;
    res_valid = v; res_chan = ch; res_seq = seq; res_data = d;
    reg_we = we; reg_addr = a; reg_wdata = wd;
    hit = v && m_en && m_mask[ch] && f_match(d);
    nf = m_flags;
    if (we && a == 3'd4) nf &= ~wd;
    if (we && a == 3'd5) nf = '0;
    if (hit) nf[ch] = 1'b1;
    @(negedge clk);
    res_valid = 1'b0; reg_we = 1'b0;
    m_flags = nf;
    m_evt = hit && f_seq_ok(seq);
    chk_outs(tag);
  endtask

  task automatic res(input string tag, input logic [3:0] ch, input bit seq, input logic [15:0] d);
    drive(tag, 1'b1, ch, seq, d, 1'b0, 3'd4, 16'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    for (int a = 0; a < 6; a++) begin
      reg_addr = 3'(a); #1;
      chk("R1 register reset", reg_rdata, 16'd0);
    end
    chk("R1 irq reset", irq_o, 1'b0);
    chk("R1 event reset", cmp_evt_o, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);

    cfg(1, 1, 0, 2'd0, 16'd100, 16'd200, 16'hFFFF);
    reg_addr = 3'd0; #1; chk("R10 ctl readback", reg_rdata, 16'h0003);
    reg_addr = 3'd1; #1; chk("R10 lo readback", reg_rdata, 16'd100);
    reg_addr = 3'd2; #1; chk("R10 hi readback", reg_rdata, 16'd200);
    reg_addr = 3'd3; #1; chk("R10 mask readback", reg_rdata, 16'hFFFF);

    res("R2 equal low", 4'd3, 0, 16'd100);
    res("R2 below low", 4'd3, 0, 16'd99);
    res("R2 above high", 4'd5, 1, 16'd201);
    res("R2 equal high", 4'd6, 0, 16'd200);
    chk("R5 sticky", m_flags, 16'h0028);

    wr(3'd0, 16'h0001);
    chk_outs("R8 irq disabled");
    wr(3'd0, 16'h0003);
    chk_outs("R8 irq enabled");

    wr(3'd4, 16'h0008);
    chk_outs("R6 clear one");
    reg_addr = 3'd5; #1; chk("R6 addr5 reads zero", reg_rdata, 16'd0);

    cfg(1, 1, 1, 2'd0, 16'd100, 16'd200, 16'hFFFF);
    res("R3 equal low", 4'd1, 0, 16'd100);
    res("R3 equal high", 4'd2, 1, 16'd200);
    res("R3 above high", 4'd7, 0, 16'd201);
    res("R3 below low", 4'd8, 0, 16'd99);

    wr(3'd3, 16'hFDFF);
    res("R4 masked channel", 4'd9, 0, 16'd150);
    wr(3'd0, 16'h000E);
    res("R4 disabled", 4'd10, 0, 16'd150);
    wr(3'd0, 16'h0007);

    drive("R7 clear all with hit", 1, 4'd4, 0, 16'd150, 1, 3'd5, 16'd0);
    drive("R7 clear one with hit", 1, 4'd4, 1, 16'd160, 1, 3'd4, 16'h0010);

    for (int s = 0; s < 4; s++) begin
      wr(3'd0, {11'd0, 2'(s), 3'b111});
      res("R9 filter seq A", 4'd11, 0, 16'd150);
      res("R9 filter seq B", 4'd12, 1, 16'd150);
    end

    wr(3'd5, 16'd0);
    chk_outs("R6 clear all");

    for (int blk = 0; blk < 15; blk++) begin
      logic [15:0] lo, hi;
      lo = 16'($urandom_range(0, 60000));
      hi = 16'(lo + $urandom_range(0, 4000));
      cfg($urandom_range(0, 9) != 0, $urandom_range(0, 1), $urandom_range(0, 1),
          2'($urandom_range(0, 3)), lo, hi, 16'($urandom));
      for (int i = 0; i < 200; i++) begin
        logic [15:0] d;
        int pick = $urandom_range(0, 5);
        if (pick == 0)      d = lo;
        else if (pick == 1) d = hi;
        else if (pick == 2) d = 16'(lo - 1);
        else if (pick == 3) d = 16'(hi + 1);
        else                d = 16'($urandom);
        if ($urandom_range(0, 15) == 0)
          drive("R5 R6 R7 random clear", $urandom_range(0, 1), 4'($urandom), 1'($urandom),
                d, 1, ($urandom_range(0, 3) == 0) ? 3'd5 : 3'd4, 16'($urandom));
        else
          drive("R2 R3 R4 R9 random", $urandom_range(0, 3) != 0, 4'($urandom),
                1'($urandom), d, 0, 3'd4, 16'd0);
      end
    end

    done = 1;
    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule